// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter with Per-State Decode

This block is an N-stage twisted-ring counter. On each enabled clock every stage passes its bit to the next higher stage, and stage 0 takes the complement of the top stage. The counter steps through 2N states and changes exactly one bit per step. Every state, and every run of neighbouring states, can be told apart by one two-input AND of two state bits. The block supplies one such AND per state as a one-hot decode bus. Because only one bit moves per step, the decode bus is free of glitches.

A plain shift ring holds on to any pattern it happens to contain. If it powers up in a pattern such as 0101 or 0011, that pattern circulates for ever. This block checks every cycle for a pattern that lies outside the cycle. It raises a flag for such a pattern and clears the ring on the next edge.

A preload port writes an arbitrary pattern into the ring. It exists so that verification can reach every pattern, including the illegal ones.

Top module: `twisted_ring_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the next `state` is all zeros. Reset overrides every other input.
- R2: With `en` high and a legal `state`, each edge loads `{state[N-2:0], ~state[N-1]}`: stage i+1 takes stage i, and stage 0 takes the inverse of stage N-1.
- R3: Starting from zero, the sequence has period 2N. For N=3 it reads 000, 001, 011, 111, 110, 100. State number k has its low k bits set for k ≤ N. For N < k < 2N, its low k−N bits are clear and all other bits are set.
- R4: With `en` low, `tload` low and a legal `state`, `state` keeps its value.
- R5: When `illegal` is low, `dec` is one-hot and bit k marks state number k as defined in R3.
- R6: Every enabled step from a legal state changes exactly one bit of `state`.
- R7: `illegal` is high exactly when `state` has more than one place where adjacent bits differ. The comparison does not wrap from bit N−1 to bit 0.
- R8: If `illegal` is high and `tload` is low at an edge, the next `state` is all zeros, whatever the level of `en`.
- R9: With `rst` low and `tload` high, an edge loads `tload_val` into `state`. This overrides `en` and the recovery of R8.
- R10: After any of the 2^N patterns is preloaded, `state` is back in the legal cycle one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to all zeros |
| en | input | 1 | Advance one step |
| tload | input | 1 | Test preload strobe |
| tload_val | input | N | Pattern written by `tload` |
| state | output | N | Raw ring contents |
| dec | output | 2N | One-hot state decode |
| illegal | output | 1 | Pattern lies outside the cycle |

## Verification
`state` is a register, so every control input (`rst`, `tload`, `en`, or a detected illegal pattern) shows its effect in `state` one edge later. `dec` and `illegal` are combinational in `state`, so they are valid in the same cycle as the `state` they describe. The bench drives its inputs on the falling edge and samples one falling edge after the rising edge that should act on them. Each result is therefore read half a period after it becomes due. For every one of the 2^N preloaded patterns, the bench checks `illegal` before recovery and checks `state` one clock after it.

// File: rtl/twisted_ring_counter.sv
module twisted_ring_counter #(
  parameter int N = 4,
  localparam int S = 2 * N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tload,
  input  logic [N-1:0] tload_val,
  output logic [N-1:0] state,
  output logic [S-1:0] dec,
  output logic         illegal
);

  logic [N-2:0] edges;

  assign edges   = state[N-1:1] ^ state[N-2:0];
  assign illegal = (edges & (edges - 1'b1)) != '0;

  always_ff @(posedge clk) begin
    if (rst)          state <= '0;
    else if (tload)   state <= tload_val;
    else if (illegal) state <= '0;
    else if (en)      state <= {state[N-2:0], ~state[N-1]};
  end

  assign dec[0] = ~state[N-1] & ~state[0];
  assign dec[N] =  state[N-1] &  state[0];

  for (genvar k = 1; k < N; k++) begin : g_dec
    assign dec[k]     =  state[k-1] & ~state[k];
    assign dec[N + k] = ~state[k-1] &  state[k];
  end

endmodule

// File: rtl/twisted_ring_checker.sv
module twisted_ring_checker #(
  parameter int N = 4,
  localparam int S = 2 * N
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         tload,
  input logic [N-1:0] tload_val,
  input logic [N-1:0] state,
  input logic [S-1:0] dec,
  input logic         illegal
);

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> state == '0);

  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    tload |=> state == $past(tload_val));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !tload && !illegal) |=> $stable(state));

  assert_one_bit_step_R6: assert property (@(posedge clk) disable iff (rst)
    (en && !tload && !illegal) |=> $countones(state ^ $past(state)) == 1);

  assert_recover_R8: assert property (@(posedge clk) disable iff (rst)
    (illegal && !tload) |=> state == '0);

  assert_decode_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    !illegal |-> $onehot(dec));

endmodule

bind twisted_ring_counter twisted_ring_checker #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tload(tload), .tload_val(tload_val),
  .state(state), .dec(dec), .illegal(illegal)
);

// File: tb/test_twisted_ring_counter.sv
module test_twisted_ring_counter;
  localparam int N = 4;
  localparam int S = 2 * N;

  logic clk = 0, rst = 1, en = 0, tload = 0;
  logic [N-1:0] tload_val = '0;
  logic [N-1:0] state;
  logic [S-1:0] dec;
  logic illegal;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twisted_ring_counter #(.N(N)) i_twisted_ring_counter (
    .clk(clk), .rst(rst), .en(en), .tload(tload), .tload_val(tload_val),
    .state(state), .dec(dec), .illegal(illegal)
  );

  function automatic logic [N-1:0] seq_val(int k);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++)
      if (k <= N) v[i] = (i < k);
      else        v[i] = (i >= k - N);
    return v;
  endfunction

  function automatic int bounds(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N - 1; i++) if (v[i] != v[i+1]) c++;
    return c;
  endfunction

  function automatic int seq_index(logic [N-1:0] v);
    for (int k = 0; k < S; k++) if (seq_val(k) == v) return k;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1; en = 1; tload = 1; tload_val = '1;
    tick();
    chk("R1 reset state", 32'(state), 0);
    chk("R1 reset illegal", 32'(illegal), 0);
    rst = 0; tload = 0; en = 0;
  endtask

  task automatic t_walk;
    en = 1;
    for (int k = 1; k <= 2 * S + 1; k++) begin
      logic [N-1:0] prev = state;
      tick();
      chk("R2 R3 sequence", 32'(state), 32'(seq_val(k % S)));
      chk("R2 feedback", 32'(state), 32'({prev[N-2:0], ~prev[N-1]}));
      chk("R6 one bit change", 32'($countones(state ^ prev)), 1);
      chk("R5 decode", 32'(dec), 32'(1) << (k % S));
      chk("R7 legal flag", 32'(illegal), 0);
    end
    en = 0;
  endtask

  task automatic t_hold;
    logic [N-1:0] keep = state;
    en = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 hold", 32'(state), 32'(keep));
    end
  endtask

  task automatic t_preload_all(input logic use_en);
    for (int v = 0; v < (1 << N); v++) begin
      logic [N-1:0] pv = v[N-1:0];
      int b = bounds(pv);
      en = use_en; tload = 1; tload_val = pv;
      tick();
      chk("R9 preload", 32'(state), 32'(pv));
      chk("R7 illegal flag", 32'(illegal), 32'(b > 1));
      if (b <= 1) chk("R5 decode preload", 32'(dec), 32'(1) << seq_index(pv));
      tload = 0;
      tick();
      if (b > 1)       chk("R8 recover", 32'(state), 0);
      else if (use_en) chk("R2 step after load", 32'(state), 32'(seq_val((seq_index(pv) + 1) % S)));
      else             chk("R4 hold after load", 32'(state), 32'(pv));
      chk("R10 legal after one clock", 32'(illegal), 0);
    end
    en = 0;
  endtask

  task automatic t_load_over_recover;
    tload = 1; tload_val = 4'b0101; en = 1;
    tick();
    tload_val = 4'b1010;
    tick();
    chk("R9 load beats recovery", 32'(state), 32'(4'b1010));
    tload = 0; en = 0;
    tick();
    chk("R8 recover with en low", 32'(state), 0);
  endtask

  task automatic t_mid_reset;
    en = 1;
    repeat (3) tick();
    rst = 1;
    tick();
    chk("R1 mid-run reset", 32'(state), 0);
    rst = 0;
    tick();
    chk("R3 restart", 32'(state), 32'(seq_val(1)));
    en = 0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_walk();
    t_hold();
    t_preload_all(1'b0);
    t_preload_all(1'b1);
    t_load_over_recover();
    t_mid_reset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule